// File: doc/BRIEF.md
# UART Register-Side Command and Mode Controller

This block is the software-facing half of a UART. It sits on a plain 8-bit memory-mapped bus that decodes six address bits. It holds two mode bytes, and both are reached at one address through a pointer that advances after each write. It decodes a command byte into three independent operation fields: a general field, a transmitter field and a receiver field. It keeps the transmitter and receiver enables, a one-byte transmit holding register, a small receive FIFO and a break-change flag. Interrupt status is ANDed with a mask to drive a single interrupt line.

Bytes that leave the transmitter appear on `tx_data` with a one-cycle `tx_valid` strobe, and the downstream side always takes them. Received bytes and break events arrive on strobed inputs from the serial side. Bit timing, baud generation and break generation live elsewhere.

Bus map on `bus_addr[5:0]`:
- 0x00: mode byte chosen by the pointer.
- 0x04: status (read).
- 0x08: command (write).
- 0x0C: receive data (read) or transmit data (write).
- 0x14: interrupt status (read) or interrupt mask (write).

All other reads return 0. Writes to 0x04 and 0x10 are discarded.

Top module: `uart_ctl`

## Requirements
- R1: After reset the status byte reads 0x08 (only the transmitter-empty bit), interrupt status and mask are 0, `irq` and `tx_valid` are low, both mode bytes are 0 and the pointer selects the first mode byte.
- R2: A write at 0x00 stores into the mode byte chosen by the pointer and then points it at the second byte; further writes keep landing in the second byte; a read at 0x00 returns the selected byte.
- R3: A command whose bits [6:4] equal 1 returns the mode pointer to the first mode byte.
- R4: Command bits [3:2] = 1 enable the transmitter and = 2 disable it; 0 and 3 leave it alone; status bit 2 (transmit ready) always equals the transmitter enable.
- R5: A write at 0x0C with the transmitter enabled raises `tx_valid` for exactly the following cycle with that byte on `tx_data`, and status bit 3 (transmitter empty) stays 1.
- R6: A write at 0x0C with the transmitter disabled holds the byte, clears status bit 3 and sends nothing; a later enable command sends the held byte once and sets bit 3 again.
- R7: A command whose bits [6:4] equal 3 disables the transmitter, sets status bit 3, clears bit 2 and discards any held byte, so a later enable sends nothing.
- R8: Command bits [1:0] = 1 enable the receiver and = 2 disable it. A `rx_valid` byte is stored only while the receiver is enabled and the FIFO is not full. Bits [6:4] = 2 disable the receiver and empty the FIFO.
- R9: Reads at 0x0C return received bytes oldest first and remove them; a read of an empty FIFO returns 0. Status bit 0 is set while the FIFO holds data, bit 1 while it holds FIFO_DEPTH bytes, and bits 7:4 are always 0.
- R10: A `rx_break` pulse stores a 0 byte even while the receiver is disabled, replaces the newest byte when the FIFO is full, and sets interrupt status bit 2. A command with bits [6:4] = 5 clears that bit.
- R11: Interrupt status bit 0 equals status bit 2. Bit 1 equals status bit 1 when the first mode byte has bit 6 set, and status bit 0 otherwise. Bits 7:3 read 0. `irq` is high exactly when interrupt status AND mask is nonzero.
- R12: Commands with bits [6:4] equal to 0, 4, 6 or 7 and all-zero enable fields, and writes at 0x04 and 0x10, change no readable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read at 0x0C removes a byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break detected on the line |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
Some rules are checked on every cycle by the assertions. Transmit ready always equals the transmitter enable. A transmit strobe only occurs with the transmitter enabled and empty. FIFO-full implies receive-ready. A mode write always leaves the pointer on the second byte. A break always sets the break-change flag. Bytes offered to a disabled receiver never change the FIFO, and `irq` is never high with a zero mask. Only the bench scenarios can show the ordering effects: the data values and the oldest-first FIFO order, a held byte sent on a later enable, a byte discarded by a transmitter reset, a break overwriting the newest entry, and the mode-byte choice between ready and full for the receive interrupt.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

  localparam logic [5:0] OFS_MODE = 6'h00;
  localparam logic [5:0] OFS_STAT = 6'h04;
  localparam logic [5:0] OFS_CMD  = 6'h08;
  localparam logic [5:0] OFS_DATA = 6'h0C;
  localparam logic [5:0] OFS_INT  = 6'h14;

  localparam int MODE_FULL_SEL_BIT = 6;

  typedef enum logic [2:0] {
    GEN_NOP     = 3'd0,
    GEN_PTR_RST = 3'd1,
    GEN_RX_RST  = 3'd2,
    GEN_TX_RST  = 3'd3,
    GEN_ERR_RST = 3'd4,
    GEN_BRK_CLR = 3'd5,
    GEN_BRK_ON  = 3'd6,
    GEN_BRK_OFF = 3'd7
  } gen_op_e;

  typedef enum logic [1:0] {
    EN_KEEP = 2'd0,
    EN_ON   = 2'd1,
    EN_OFF  = 2'd2,
    EN_RSVD = 2'd3
  } en_op_e;

  typedef struct packed {
    gen_op_e gen;
    en_op_e  tx;
    en_op_e  rx;
  } cmd_t;

  function automatic cmd_t split_cmd(input logic [7:0] b);
    return cmd_t'(b[6:0]);
  endfunction

  function automatic logic [7:0] pack_status(input logic tx_emp, input logic tx_rdy,
                                             input logic full, input logic nonempty);
    return {4'b0000, tx_emp, tx_rdy, full, nonempty};
  endfunction

  function automatic logic rx_irq_cond(input logic use_full, input logic full,
                                       input logic nonempty);
    return use_full ? full : nonempty;
  endfunction

  function automatic logic [7:0] pack_isr(input logic brk, input logic rxc,
                                          input logic txr);
    return {5'b00000, brk, rxc, txr};
  endfunction

endpackage

// File: rtl/uart_ctl_cmd_decode.sv
module uart_ctl_cmd_decode
  import uart_ctl_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  output logic       ptr_rst,
  output logic       rx_reset,
  output logic       tx_reset,
  output logic       brk_clr,
  output logic       tx_on,
  output logic       tx_off,
  output logic       rx_on,
  output logic       rx_off
);
  cmd_t c;
  assign c = split_cmd(cmd_byte);

  always_comb begin
    ptr_rst  = 1'b0;
    rx_reset = 1'b0;
    tx_reset = 1'b0;
    brk_clr  = 1'b0;
    if (cmd_wr) begin
      case (c.gen)
        GEN_PTR_RST: ptr_rst  = 1'b1;
        GEN_RX_RST:  rx_reset = 1'b1;
        GEN_TX_RST:  tx_reset = 1'b1;
        GEN_BRK_CLR: brk_clr  = 1'b1;
        default:     ;
      endcase
    end
  end

  assign tx_on  = cmd_wr && (c.tx == EN_ON);
  assign tx_off = cmd_wr && (c.tx == EN_OFF);
  assign rx_on  = cmd_wr && (c.rx == EN_ON);
  assign rx_off = cmd_wr && (c.rx == EN_OFF);
endmodule

// File: rtl/uart_ctl_tx.sv
module uart_ctl_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_reset,
  input  logic       tx_on,
  input  logic       tx_off,
  input  logic       hold_wr,
  input  logic [7:0] hold_data,
  output logic       tx_en,
  output logic       tx_emp,
  output logic       tx_rdy,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  logic       en_q, emp_q, rdy_q;
  logic [7:0] hold_q;
  logic       en_n, emp_n, rdy_n, send;
  logic [7:0] hold_n;

  always_comb begin
    en_n   = en_q;
    emp_n  = emp_q;
    rdy_n  = rdy_q;
    hold_n = hold_q;
    send   = 1'b0;
    if (tx_reset) begin
      en_n  = 1'b0;
      emp_n = 1'b1;
      rdy_n = 1'b0;
    end
    if (tx_on || tx_off) begin
      en_n = tx_on;
      if (en_n && !emp_n) begin
        send  = 1'b1;
        emp_n = 1'b1;
      end
      rdy_n = en_n;
    end
    if (hold_wr) begin
      hold_n = hold_data;
      emp_n  = 1'b0;
      if (en_n) begin
        send  = 1'b1;
        emp_n = 1'b1;
      end
      rdy_n = en_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      emp_q    <= 1'b1;
      rdy_q    <= 1'b0;
      hold_q   <= 8'h00;
      tx_valid <= 1'b0;
      tx_data  <= 8'h00;
    end else begin
      en_q     <= en_n;
      emp_q    <= emp_n;
      rdy_q    <= rdy_n;
      hold_q   <= hold_n;
      tx_valid <= send;
      if (send) tx_data <= hold_n;
    end
  end

  assign tx_en  = en_q;
  assign tx_emp = emp_q;
  assign tx_rdy = rdy_q;
endmodule

// File: rtl/uart_ctl_rxfifo.sv
module uart_ctl_rxfifo #(
  parameter int DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     flush,
  input  logic                     pop,
  input  logic                     push_data,
  input  logic                     push_brk,
  input  logic [7:0]               data_in,
  output logic [7:0]               head,
  output logic [$clog2(DEPTH):0]   count,
  output logic                     nonempty,
  output logic                     full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop, do_push, overwrite;
  logic [AW-1:0] wr_idx;
  logic [7:0]    wr_val;

  always_comb begin
    do_pop    = pop && (cnt_q != '0);
    do_push   = push_data || push_brk;
    overwrite = push_brk && (cnt_q == CW'(DEPTH)) && !do_pop;
    wr_idx    = rd_q + (overwrite ? AW'(cnt_q - CW'(1)) : AW'(cnt_q));
    wr_val    = push_brk ? 8'h00 : data_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_q + AW'(do_pop);
      cnt_q <= cnt_q - CW'(do_pop) + CW'(do_push && !overwrite);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && do_push) mem[wr_idx] <= wr_val;
  end

  assign head     = mem[rd_q];
  assign count    = cnt_q;
  assign nonempty = (cnt_q != '0);
  assign full     = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/uart_ctl.sv
module uart_ctl
  import uart_ctl_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_break,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       irq
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic [7:0] mode_q [2];
  logic       mode_ptr, rx_en, brk_q;
  logic [7:0] imask;

  // named events for the checker
  logic       mode_wr, cmd_wr, data_wr, mask_wr, pop;
  logic       ptr_rst, rx_reset, tx_reset, brk_clr, tx_on, tx_off, rx_on, rx_off;
  logic       tx_en, tx_emp, tx_rdy;
  logic [7:0] fifo_head;
  logic [CW-1:0] rx_count;
  logic       nonempty, full, rx_accept;
  logic [7:0] status, isr;

  assign mode_wr = bus_wr && (bus_addr == OFS_MODE);
  assign cmd_wr  = bus_wr && (bus_addr == OFS_CMD);
  assign data_wr = bus_wr && (bus_addr == OFS_DATA);
  assign mask_wr = bus_wr && (bus_addr == OFS_INT);
  assign pop     = bus_rd && (bus_addr == OFS_DATA);

  uart_ctl_cmd_decode u_dec (
    .cmd_wr(cmd_wr), .cmd_byte(bus_wdata),
    .ptr_rst(ptr_rst), .rx_reset(rx_reset), .tx_reset(tx_reset), .brk_clr(brk_clr),
    .tx_on(tx_on), .tx_off(tx_off), .rx_on(rx_on), .rx_off(rx_off)
  );

  uart_ctl_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tx_reset(tx_reset), .tx_on(tx_on), .tx_off(tx_off),
    .hold_wr(data_wr), .hold_data(bus_wdata),
    .tx_en(tx_en), .tx_emp(tx_emp), .tx_rdy(tx_rdy),
    .tx_valid(tx_valid), .tx_data(tx_data)
  );

  assign rx_accept = rx_valid && rx_en && !full && !rx_break;

  uart_ctl_rxfifo #(.DEPTH(FIFO_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .flush(rx_reset), .pop(pop),
    .push_data(rx_accept), .push_brk(rx_break), .data_in(rx_data),
    .head(fifo_head), .count(rx_count), .nonempty(nonempty), .full(full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q[0] <= 8'h00;
      mode_q[1] <= 8'h00;
      mode_ptr  <= 1'b0;
      rx_en     <= 1'b0;
      brk_q     <= 1'b0;
      imask     <= 8'h00;
    end else begin
      if (mode_wr) begin
        mode_q[mode_ptr] <= bus_wdata;
        mode_ptr         <= 1'b1;
      end else if (ptr_rst) begin
        mode_ptr <= 1'b0;
      end
      if (rx_on)                   rx_en <= 1'b1;
      else if (rx_off || rx_reset) rx_en <= 1'b0;
      if (rx_break)     brk_q <= 1'b1;
      else if (brk_clr) brk_q <= 1'b0;
      if (mask_wr) imask <= bus_wdata;
    end
  end

  assign status = pack_status(tx_emp, tx_rdy, full, nonempty);
  assign isr    = pack_isr(brk_q,
                           rx_irq_cond(mode_q[0][MODE_FULL_SEL_BIT], full, nonempty),
                           tx_rdy);
  assign irq    = |(isr & imask);

  always_comb begin
    case (bus_addr)
      OFS_MODE: bus_rdata = mode_q[mode_ptr];
      OFS_STAT: bus_rdata = status;
      OFS_DATA: bus_rdata = nonempty ? fifo_head : 8'h00;
      OFS_INT:  bus_rdata = isr;
      default:  bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/uart_ctl_chk.sv
module uart_ctl_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [5:0]    bus_addr,
  input logic          tx_valid,
  input logic          tx_en,
  input logic [7:0]    status,
  input logic [7:0]    isr,
  input logic [7:0]    imask,
  input logic          irq,
  input logic          mode_ptr,
  input logic          rx_valid,
  input logic          rx_break,
  input logic          rx_en,
  input logic          pop,
  input logic [CW-1:0] rx_count
);
  a_r4_ready_tracks_enable: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] == tx_en);

  a_r5_send_when_enabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_en && status[3]));

  a_r9_full_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] |-> status[0]);

  a_r9_status_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:4] == 4'h0);

  a_r2_ptr_after_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 6'h00) |=> mode_ptr);

  a_r10_break_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    rx_break |=> isr[2]);

  a_r8_disabled_rx_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_en && !rx_break && !pop && !bus_wr) |=> $stable(rx_count));

  a_r11_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (imask != 8'h00));

  a_r11_isr_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    isr[7:3] == 5'h00);
endmodule

bind uart_ctl uart_ctl_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .tx_valid(tx_valid), .tx_en(tx_en), .status(status), .isr(isr),
  .imask(imask), .irq(irq), .mode_ptr(mode_ptr), .rx_valid(rx_valid),
  .rx_break(rx_break), .rx_en(rx_en), .pop(pop), .rx_count(rx_count)
);

// File: tb/sim_uart_ctl.sv
`timescale 1ns/1ps
module sim_uart_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_valid, irq;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_ctl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_break(rx_break), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog got %0d exp <20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic bwr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic brd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_valid = 1'b1;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic rx_brk();
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    peek(6'h04, v); chk("R1 status", v, 8'h08);
    peek(6'h14, v); chk("R1 isr", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    chk("R1 tx_valid", {7'b0, tx_valid}, 8'h00);
    peek(6'h00, v); chk("R1 mode", v, 8'h00);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    bwr(6'h00, 8'h11);
    bwr(6'h00, 8'h22);
    peek(6'h00, v); chk("R2 second byte", v, 8'h22);
    bwr(6'h00, 8'h33);
    peek(6'h00, v); chk("R2 stays on second", v, 8'h33);
    bwr(6'h08, 8'h10);
    peek(6'h00, v); chk("R3 ptr back to first", v, 8'h11);
  endtask

  task automatic t_ignored();
    logic [7:0] v;
    bwr(6'h04, 8'hFF);
    bwr(6'h10, 8'hFF);
    bwr(6'h08, 8'h00);
    bwr(6'h08, 8'h40);
    bwr(6'h08, 8'h60);
    bwr(6'h08, 8'h70);
    peek(6'h04, v); chk("R12 status unchanged", v, 8'h08);
    peek(6'h14, v); chk("R12 isr unchanged", v, 8'h00);
    peek(6'h00, v); chk("R12 mode unchanged", v, 8'h11);
    bwr(6'h08, 8'h0C);
    peek(6'h04, v); chk("R4 reserved tx field", v, 8'h08);
    bwr(6'h08, 8'h03);
    rx_push(8'h99);
    peek(6'h04, v); chk("R8 reserved rx field keeps rx off", v, 8'h08);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    bwr(6'h08, 8'h04);
    peek(6'h04, v); chk("R4 enable sets ready", v, 8'h0C);
    peek(6'h14, v); chk("R11 isr tx bit", v, 8'h01);
    bwr(6'h0C, 8'hA5);
    chk("R5 strobe", {7'b0, tx_valid}, 8'h01);
    chk("R5 data", tx_data, 8'hA5);
    peek(6'h04, v); chk("R5 still empty", v, 8'h0C);
    @(negedge clk);
    chk("R5 strobe one cycle", {7'b0, tx_valid}, 8'h00);
  endtask

  task automatic t_tx_hold();
    logic [7:0] v;
    bwr(6'h08, 8'h08);
    peek(6'h04, v); chk("R4 disable clears ready", v, 8'h08);
    bwr(6'h0C, 8'h3C);
    chk("R6 no strobe while off", {7'b0, tx_valid}, 8'h00);
    peek(6'h04, v); chk("R6 not empty", v, 8'h00);
    bwr(6'h08, 8'h04);
    chk("R6 held byte sent", {7'b0, tx_valid}, 8'h01);
    chk("R6 held data", tx_data, 8'h3C);
    peek(6'h04, v); chk("R6 empty again", v, 8'h0C);
    chk("R6 sent once", {7'b0, tx_valid}, 8'h00);
  endtask

  task automatic t_tx_reset();
    logic [7:0] v;
    bwr(6'h08, 8'h08);
    bwr(6'h0C, 8'h77);
    bwr(6'h08, 8'h30);
    peek(6'h04, v); chk("R7 reset sets empty", v, 8'h08);
    bwr(6'h08, 8'h04);
    chk("R7 discarded byte not sent", {7'b0, tx_valid}, 8'h00);
    peek(6'h04, v); chk("R7 re-enabled", v, 8'h0C);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    rx_push(8'h55);
    peek(6'h04, v); chk("R8 disabled drops", v, 8'h0C);
    bwr(6'h08, 8'h01);
    rx_push(8'h10); rx_push(8'h20); rx_push(8'h30); rx_push(8'h40);
    peek(6'h04, v); chk("R9 full status", v, 8'h0F);
    rx_push(8'h50);
    brd(6'h0C, v); chk("R9 order 1", v, 8'h10);
    brd(6'h0C, v); chk("R9 order 2", v, 8'h20);
    peek(6'h04, v); chk("R9 partial status", v, 8'h0D);
    brd(6'h0C, v); chk("R9 order 3", v, 8'h30);
    brd(6'h0C, v); chk("R8 full drop, order 4", v, 8'h40);
    brd(6'h0C, v); chk("R9 empty reads 0", v, 8'h00);
    rx_push(8'h61);
    bwr(6'h08, 8'h20);
    peek(6'h04, v); chk("R8 flush", v, 8'h0C);
    rx_push(8'h62);
    peek(6'h04, v); chk("R8 reset disables rx", v, 8'h0C);
  endtask

  task automatic t_break();
    logic [7:0] v;
    rx_brk();
    peek(6'h04, v); chk("R10 break stored while off", v, 8'h0D);
    peek(6'h14, v); chk("R10 isr break bit", v, 8'h07);
    brd(6'h0C, v); chk("R10 break byte", v, 8'h00);
    bwr(6'h08, 8'h50);
    peek(6'h14, v); chk("R10 break bit cleared", v, 8'h01);
    bwr(6'h08, 8'h01);
    rx_push(8'h01); rx_push(8'h02); rx_push(8'h03); rx_push(8'h04);
    rx_brk();
    brd(6'h0C, v); chk("R10 overwrite 1", v, 8'h01);
    brd(6'h0C, v); chk("R10 overwrite 2", v, 8'h02);
    brd(6'h0C, v); chk("R10 overwrite 3", v, 8'h03);
    brd(6'h0C, v); chk("R10 newest replaced", v, 8'h00);
    bwr(6'h08, 8'h50);
  endtask

  task automatic t_irq();
    logic [7:0] v;
    bwr(6'h14, 8'h02);
    chk("R11 masked out", {7'b0, irq}, 8'h00);
    bwr(6'h14, 8'h01);
    chk("R11 tx irq", {7'b0, irq}, 8'h01);
    bwr(6'h08, 8'h08);
    chk("R11 irq drops with ready", {7'b0, irq}, 8'h00);
    bwr(6'h08, 8'h10);
    bwr(6'h00, 8'h40);
    bwr(6'h14, 8'h02);
    rx_push(8'hA1);
    peek(6'h14, v); chk("R11 full-select, one byte", v, 8'h00);
    chk("R11 irq low one byte", {7'b0, irq}, 8'h00);
    rx_push(8'hA2); rx_push(8'hA3); rx_push(8'hA4);
    peek(6'h14, v); chk("R11 full-select full", v, 8'h02);
    chk("R11 irq on full", {7'b0, irq}, 8'h01);
    bwr(6'h08, 8'h20);
    chk("R11 irq after flush", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_mode();
    t_ignored();
    t_tx();
    t_tx_hold();
    t_tx_reset();
    t_rx();
    t_break();
    t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule